// File: doc/BRIEF.md
# I2C Master Bit Timing Engine

This block is the bit-level engine that sits below an I2C master controller. The controller hands it one request at a time: a START, a repeated START, a STOP, or the transfer of a single data bit. The engine then sequences the open-drain SCL and SDA lines through the required edges. Every interval between edges is taken from its own count input, in module clock cycles, so the controller can tune setup, hold, low, high and sample timing separately.

Both lines are open-drain. The engine only asserts a drive-low enable per line and reads the resolved line level back through a synchronizer. The high phase of SCL is counted only once SCL is seen high, so a slave that stretches the clock lengthens the bit instead of eating into the high time. A bounded wait for SCL to rise is optional. The current phase is exported as a fixed 3-bit code. A watchdog raises a sticky flag when a non-idle phase lasts too long.

Top module: `i2c_bit_engine`

## Requirements
- R1: While reset is asserted and after it is released, both drive-low outputs are 0, `state_o` is 0, `done_o` is 0 and `stall_flag_o` is 0.
- R2: A START request (op 0) drives SDA low in its accept cycle with SCL released, and drives SCL low `start_hold_i` cycles later. A count of 0 acts as 1. `state_o` reads 1 in between.
- R3: A bit request (op 3) updates SDA `sda_hold_i` cycles after the accept edge. SDA is released for `tx_bit_i`=1 and driven low for 0. `state_o` reads 2 during this wait.
- R4: SCL is released `low_cnt_i` cycles after that SDA update, and SCL stays driven low throughout. `state_o` reads 3 during this wait.
- R5: After SCL is released, `state_o` reads 4 until SCL reads high through a SYNC_STAGES-flop synchronizer. SCL is driven low again `high_cnt_i` cycles after that, so the drive is released for `high_cnt_i`+SYNC_STAGES+1 cycles after the line rises. A stretched SCL therefore delays the high phase without shortening it.
- R6: A nonzero `wait_high_i` ends state 4 after that many cycles even if SCL never reads high. A value of 0 waits without limit.
- R7: For a bit, `rx_bit_o` is the synchronized SDA taken `sample_pt_i` cycles into the high phase, or taken at its end if the sample point lies beyond it. It is presented with `done_o`, and SDA does not change during the high phase.
- R8: A repeated START (op 1) releases SDA, releases SCL after `low_cnt_i` cycles, and drives SDA low `restart_setup_i`+SYNC_STAGES+1 cycles after SCL rises. It then drives SCL low `start_hold_i` cycles later.
- R9: A STOP (op 2) drives SDA low and releases SCL after `low_cnt_i` cycles. It releases SDA `stop_setup_i`+SYNC_STAGES+1 cycles after SCL rises, reads `state_o`=6 with both lines released, and pulses `done_o` `stop_hold_i` cycles later.
- R10: `req_i` is accepted only when `state_o` is 0, with `op_i` coding 0 START, 1 repeated START, 2 STOP, 3 bit. Each request produces exactly one single-cycle `done_o` pulse, and a request raised while busy is ignored.
- R11: `state_o` codes: 0 idle, 1 start, 2 negative-edge/SDA hold, 3 low, 4 rising/wait-high, 5 high, 6 stop. Code 7 never appears.
- R12: `stall_flag_o` sets when a non-idle state stays unchanged for about 2^min(`stall_lim_i`,23) cycles. It stays set until the next START is accepted, and idle time never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, taken in idle |
| op_i | input | 2 | Request kind |
| tx_bit_i | input | 1 | Bit to send for a bit request |
| done_o | output | 1 | One-cycle completion pulse |
| rx_bit_o | output | 1 | Sampled SDA of the last bit |
| low_cnt_i | input | 9 | SCL low count |
| high_cnt_i | input | 9 | SCL high count |
| start_hold_i | input | 9 | SDA fall to SCL fall for START |
| restart_setup_i | input | 9 | SCL high to SDA fall for repeated START |
| stop_setup_i | input | 9 | SCL high to SDA rise for STOP |
| stop_hold_i | input | 9 | Wait after SDA rise before done |
| sda_hold_i | input | 9 | Delay before SDA update in a bit |
| sample_pt_i | input | 9 | Sample offset into the high phase |
| wait_high_i | input | 7 | Bound on waiting for SCL high, 0 unbounded |
| stall_lim_i | input | 5 | Watchdog exponent |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | Drive SCL low |
| sda_low_o | output | 1 | Drive SDA low |
| state_o | output | 3 | Current state code |
| stall_flag_o | output | 1 | Sticky stuck-state flag |

## Verification
The bench holds SCL low from a bus model to stretch the clock. A design that started the high count at release rather than at the observed rise would return SCL low too soon after the line rose. It moves a slave SDA release across the high phase with an early and a late sample point. A design that sampled at the wrong offset would return the wrong bit for one of the two. It raises a STOP request in the middle of a bit. An engine that queued or took that request would emit a second done pulse or release SCL. It holds a state long enough to trip the watchdog. A flag that is not sticky, is not cleared by START, or counts idle time would be caught.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_NEG   = 3'd2,
    ST_LOW   = 3'd3,
    ST_POS   = 3'd4,
    ST_HIGH  = 3'd5,
    ST_STOP  = 3'd6
  } bit_state_e;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_RESTART = 2'd1,
    OP_STOP    = 2'd2,
    OP_BIT     = 2'd3
  } bit_op_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b1;
          else         sync_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b1;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt, lim_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  // a zero count behaves as one cycle
  always_comb begin
    cnt_nxt = {1'b0, cnt_q} + 1'b1;
    lim_eff = (limit_i == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, limit_i};
    hit_o   = (cnt_nxt >= lim_eff);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/i2c_stall_watch.sv
module i2c_stall_watch
  import i2c_bit_pkg::*;
#(
  parameter int SW = 24,
  parameter int LW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    state_i,
  input  logic          clr_i,
  input  logic [LW-1:0] lim_i,
  output logic          flag_o
);
  logic [2:0]    prev_q;
  logic [SW-1:0] run_q;
  logic          flag_q;
  logic [LW-1:0] lim_c;
  logic [SW:0]   target, run_nxt;
  logic          trip;

  always_comb begin
    lim_c   = (lim_i > LW'(SW - 1)) ? LW'(SW - 1) : lim_i;
    target  = {{SW{1'b0}}, 1'b1} << lim_c;
    run_nxt = {1'b0, run_q} + 1'b1;
    trip    = (state_i != ST_IDLE) && (state_i == prev_q) && (run_nxt >= target);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= ST_IDLE;
      run_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= state_i;
      if (state_i == ST_IDLE || state_i != prev_q) run_q <= '0;
      else if (!(&run_q))                          run_q <= run_q + 1'b1;
      if (clr_i)     flag_q <= 1'b0;
      else if (trip) flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  p_flag_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int WAIT_W      = 7,
  parameter int LIM_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int STALL_W     = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic              tx_bit_i,
  output logic              done_o,
  output logic              rx_bit_o,
  input  logic [CNT_W-1:0]  low_cnt_i,
  input  logic [CNT_W-1:0]  high_cnt_i,
  input  logic [CNT_W-1:0]  start_hold_i,
  input  logic [CNT_W-1:0]  restart_setup_i,
  input  logic [CNT_W-1:0]  stop_setup_i,
  input  logic [CNT_W-1:0]  stop_hold_i,
  input  logic [CNT_W-1:0]  sda_hold_i,
  input  logic [CNT_W-1:0]  sample_pt_i,
  input  logic [WAIT_W-1:0] wait_high_i,
  input  logic [LIM_W-1:0]  stall_lim_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic [2:0]        state_o,
  output logic              stall_flag_o
);
  localparam int PAD_W = CNT_W - WAIT_W;

  bit_state_e state_q, state_d;
  bit_op_e    op_q, op_d;
  logic       tx_q, tx_d;
  logic       scl_low_q, scl_low_d, sda_low_q, sda_low_d;
  logic       done_q, done_d;
  logic       rx_q, rx_d, samp_q, samp_d;
  logic       scl_s, sda_s;
  logic       tim_clr, tim_hit, stall_clr;
  logic [CNT_W-1:0] tim_lim, tim_cnt;
  logic [CNT_W:0]   samp_eff, high_eff, cnt_nxt;
  logic             samp_hit, samp_late;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s));
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s));

  i2c_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tim_clr),
    .limit_i(tim_lim), .cnt_o(tim_cnt), .hit_o(tim_hit));

  i2c_stall_watch #(.SW(STALL_W), .LW(LIM_W)) u_watch (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state_q), .clr_i(stall_clr),
    .lim_i(stall_lim_i), .flag_o(stall_flag_o));

  // interval that ends the current phase
  always_comb begin
    unique case (state_q)
      ST_START: tim_lim = start_hold_i;
      ST_NEG:   tim_lim = sda_hold_i;
      ST_LOW:   tim_lim = low_cnt_i;
      ST_POS:   tim_lim = {{PAD_W{1'b0}}, wait_high_i};
      ST_HIGH:  tim_lim = (op_q == OP_BIT)     ? high_cnt_i :
                          (op_q == OP_RESTART) ? restart_setup_i : stop_setup_i;
      ST_STOP:  tim_lim = stop_hold_i;
      default:  tim_lim = '0;
    endcase
  end

  always_comb begin
    samp_eff  = (sample_pt_i == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, sample_pt_i};
    high_eff  = (high_cnt_i  == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, high_cnt_i};
    cnt_nxt   = {1'b0, tim_cnt} + 1'b1;
    samp_hit  = (cnt_nxt == samp_eff);
    samp_late = (samp_eff > high_eff);
  end

  always_comb begin
    state_d   = state_q;
    op_d      = op_q;
    tx_d      = tx_q;
    scl_low_d = scl_low_q;
    sda_low_d = sda_low_q;
    done_d    = 1'b0;
    rx_d      = rx_q;
    samp_d    = samp_q;
    stall_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        op_d = bit_op_e'(op_i);
        tx_d = tx_bit_i;
        unique case (bit_op_e'(op_i))
          OP_START: begin
            state_d   = ST_START;
            sda_low_d = 1'b1;
            scl_low_d = 1'b0;
            stall_clr = 1'b1;
          end
          OP_RESTART: begin state_d = ST_LOW; sda_low_d = 1'b0; end
          OP_STOP:    begin state_d = ST_LOW; sda_low_d = 1'b1; end
          default:    state_d = ST_NEG;
        endcase
      end
      ST_START: if (tim_hit) begin
        scl_low_d = 1'b1;
        done_d    = 1'b1;
        state_d   = ST_IDLE;
      end
      ST_NEG: if (tim_hit) begin
        sda_low_d = ~tx_q;
        state_d   = ST_LOW;
      end
      ST_LOW: if (tim_hit) begin
        scl_low_d = 1'b0;
        state_d   = ST_POS;
      end
      ST_POS: if (scl_s || (wait_high_i != '0 && tim_hit)) state_d = ST_HIGH;
      ST_HIGH: begin
        unique case (op_q)
          OP_BIT: begin
            if (samp_hit) samp_d = sda_s;
            if (tim_hit) begin
              rx_d      = (samp_hit || samp_late) ? sda_s : samp_q;
              scl_low_d = 1'b1;
              done_d    = 1'b1;
              state_d   = ST_IDLE;
            end
          end
          OP_RESTART: if (tim_hit) begin
            sda_low_d = 1'b1;
            state_d   = ST_START;
          end
          default: if (tim_hit) begin
            sda_low_d = 1'b0;
            state_d   = ST_STOP;
          end
        endcase
      end
      ST_STOP: if (tim_hit) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tim_clr = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_START;
      tx_q      <= 1'b1;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
      done_q    <= 1'b0;
      rx_q      <= 1'b1;
      samp_q    <= 1'b1;
    end else begin
      state_q   <= state_d;
      op_q      <= op_d;
      tx_q      <= tx_d;
      scl_low_q <= scl_low_d;
      sda_low_q <= sda_low_d;
      done_q    <= done_d;
      rx_q      <= rx_d;
      samp_q    <= samp_d;
    end
  end

  assign done_o    = done_q;
  assign rx_bit_o  = rx_q;
  assign scl_low_o = scl_low_q;
  assign sda_low_o = sda_low_q;
  assign state_o   = state_q;

  p_state_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 3'd7);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_scl_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NEG || state_q == ST_LOW) |-> scl_low_q);
  p_sda_quiet_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIGH && op_q == OP_BIT) |=> $stable(sda_low_q));
endmodule

// File: tb/i2c_bit_engine_tb.sv
`timescale 1ns/1ps
module i2c_bit_engine_tb;
  localparam int SYNC = 2;
  localparam int WD_LIMIT = 20000;
  // {tx, slave pulls SDA, expected rx, expected SDA drive in high}
  localparam logic [3:0] VEC [5] = '{4'b1010, 4'b1100, 4'b0001, 4'b0101, 4'b1010};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, tx_bit_i = 1'b1;
  logic [1:0] op_i = 2'd0;
  logic [8:0] low_cnt = 9'd6, high_cnt = 9'd8, start_hold = 9'd5, rs_setup = 9'd4;
  logic [8:0] stop_setup = 9'd7, stop_hold = 9'd9, sda_hold = 9'd3, sample_pt = 9'd4;
  logic [6:0] wait_high = 7'd0;
  logic [4:0] stall_lim = 5'd5;
  logic scl_stretch = 1'b0, sda_slave = 1'b0;
  logic done_o, rx_bit_o, scl_low_o, sda_low_o, stall_flag_o;
  logic [2:0] state_o;
  wire scl_line = !(scl_low_o | scl_stretch);
  wire sda_line = !(sda_low_o | sda_slave);

  int cyc = 0, checks = 0, errors = 0, done_cnt = 0;
  int t_scl_fall, t_scl_rise, t_sda_fall, t_sda_rise, t_done, c0, l_rise, d0;
  logic scl_p = 1'b0, sda_p = 1'b0;

  always #2.5 clk = ~clk;

  i2c_bit_engine u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .op_i(op_i), .tx_bit_i(tx_bit_i),
    .done_o(done_o), .rx_bit_o(rx_bit_o), .low_cnt_i(low_cnt), .high_cnt_i(high_cnt),
    .start_hold_i(start_hold), .restart_setup_i(rs_setup), .stop_setup_i(stop_setup),
    .stop_hold_i(stop_hold), .sda_hold_i(sda_hold), .sample_pt_i(sample_pt),
    .wait_high_i(wait_high), .stall_lim_i(stall_lim), .scl_i(scl_line), .sda_i(sda_line),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .state_o(state_o),
    .stall_flag_o(stall_flag_o));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog R10 actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (scl_low_o && !scl_p) t_scl_fall = cyc;
    if (!scl_low_o && scl_p) t_scl_rise = cyc;
    if (sda_low_o && !sda_p) t_sda_fall = cyc;
    if (!sda_low_o && sda_p) t_sda_rise = cyc;
    if (done_o) begin t_done = cyc; done_cnt = done_cnt + 1; end
    scl_p = scl_low_o;
    sda_p = sda_low_o;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic tx);
    @(negedge clk);
    req_i = 1'b1; op_i = op; tx_bit_i = tx; c0 = cyc;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic wait_release();
    while (scl_low_o) @(negedge clk);
  endtask

  task automatic sample_case(input logic [8:0] sp, input logic exp);
    sample_pt = sp; high_cnt = 9'd20; sda_slave = 1'b1;
    issue(2'd3, 1'b1);
    wait_release();
    repeat (10) @(negedge clk);
    sda_slave = 1'b0;
    wait_done();
    chk(rx_bit_o == exp, "R7 sample point", rx_bit_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!scl_low_o && !sda_low_o && state_o == 0 && !done_o && !stall_flag_o,
        "R1 in reset", {scl_low_o, sda_low_o, state_o, done_o, stall_flag_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl_low_o && !sda_low_o && state_o == 0 && !stall_flag_o,
        "R1 after reset", {scl_low_o, sda_low_o, state_o, stall_flag_o}, 0);

    // R2 START
    issue(2'd0, 1'b1);
    chk(state_o == 1 && sda_low_o && !scl_low_o, "R2 R11 start phase", state_o, 1);
    wait_done();
    @(negedge clk);
    chk(t_scl_fall - t_sda_fall == 5, "R2 start hold", t_scl_fall - t_sda_fall, 5);
    chk(!done_o && state_o == 0, "R10 done one cycle", done_o, 0);

    // R3 R4 R5 bit timing and state codes
    issue(2'd3, 1'b1);
    chk(state_o == 2, "R11 sda hold code", state_o, 2);
    repeat (4) @(negedge clk);
    chk(state_o == 3, "R11 low code", state_o, 3);
    repeat (7) @(negedge clk);
    chk(state_o == 4, "R11 rise code", state_o, 4);
    repeat (3) @(negedge clk);
    chk(state_o == 5, "R11 high code", state_o, 5);
    wait_done();
    chk(rx_bit_o == 1'b1, "R7 idle bus reads one", rx_bit_o, 1);
    @(negedge clk);
    chk(t_sda_rise - c0 == 3 + 1, "R3 sda hold", t_sda_rise - c0, 4);
    chk(t_scl_rise - c0 == 3 + 6 + 1, "R4 low count", t_scl_rise - c0, 10);
    chk(t_scl_fall - t_scl_rise == 8 + SYNC + 1, "R5 high time", t_scl_fall - t_scl_rise, 11);

    // table of bits
    for (int i = 0; i < 5; i++) begin
      sda_slave = VEC[i][2];
      issue(2'd3, VEC[i][3]);
      while (state_o != 3'd5) @(negedge clk);
      chk(sda_low_o == VEC[i][0], "R3 sda drive in high", sda_low_o, VEC[i][0]);
      wait_done();
      chk(rx_bit_o == VEC[i][1], "R7 table rx", rx_bit_o, VEC[i][1]);
      sda_slave = 1'b0;
    end

    // R5 clock stretch
    scl_stretch = 1'b1;
    issue(2'd3, 1'b1);
    wait_release();
    repeat (12) @(negedge clk);
    chk(state_o == 4, "R5 waits for line high", state_o, 4);
    scl_stretch = 1'b0; l_rise = cyc;
    wait_done();
    @(negedge clk);
    chk(t_scl_fall - l_rise == 8 + SYNC + 1, "R5 stretched high", t_scl_fall - l_rise, 11);

    // R6 bounded wait
    wait_high = 7'd6; scl_stretch = 1'b1;
    issue(2'd3, 1'b1);
    wait_done();
    @(negedge clk);
    chk(t_scl_fall - t_scl_rise == 6 + 8, "R6 wait bound", t_scl_fall - t_scl_rise, 14);
    scl_stretch = 1'b0; wait_high = 7'd0;

    // R7 sample point
    sample_case(9'd3, 1'b0);
    sample_case(9'd18, 1'b1);
    high_cnt = 9'd8; sample_pt = 9'd4;

    // R8 repeated start
    issue(2'd1, 1'b1);
    wait_done();
    @(negedge clk);
    chk(t_sda_fall - t_scl_rise == 4 + SYNC + 1, "R8 restart setup", t_sda_fall - t_scl_rise, 7);
    chk(t_scl_fall - t_sda_fall == 5, "R8 restart hold", t_scl_fall - t_sda_fall, 5);

    // R9 stop
    issue(2'd3, 1'b1);
    wait_done();
    issue(2'd2, 1'b1);
    while (state_o != 3'd6) @(negedge clk);
    chk(!sda_low_o && !scl_low_o, "R9 R11 stop code lines free", {scl_low_o, sda_low_o}, 0);
    wait_done();
    @(negedge clk);
    chk(t_sda_rise - t_scl_rise == 7 + SYNC + 1, "R9 stop setup", t_sda_rise - t_scl_rise, 10);
    chk(t_done - t_sda_rise == 9, "R9 stop hold", t_done - t_sda_rise, 9);

    // R10 request while busy is ignored
    issue(2'd0, 1'b1);
    wait_done();
    @(negedge clk);
    d0 = done_cnt;
    issue(2'd3, 1'b1);
    issue(2'd2, 1'b1);
    wait_done();
    repeat (6) @(negedge clk);
    chk(done_cnt == d0 + 1, "R10 single done", done_cnt, d0 + 1);
    chk(state_o == 0 && scl_low_o, "R10 busy request dropped", {state_o, scl_low_o}, 1);
    issue(2'd2, 1'b1);
    wait_done();

    // R12 watchdog
    stall_lim = 5'd4;
    issue(2'd0, 1'b1);
    wait_done();
    scl_stretch = 1'b1;
    issue(2'd3, 1'b1);
    wait_release();
    repeat (8) @(negedge clk);
    chk(!stall_flag_o, "R12 no early trip", stall_flag_o, 0);
    repeat (30) @(negedge clk);
    chk(stall_flag_o, "R12 trips on stuck state", stall_flag_o, 1);
    scl_stretch = 1'b0;
    wait_done();
    issue(2'd2, 1'b1);
    wait_done();
    @(negedge clk);
    chk(stall_flag_o, "R12 sticky", stall_flag_o, 1);
    issue(2'd0, 1'b1);
    chk(!stall_flag_o, "R12 cleared by start", stall_flag_o, 0);
    wait_done();
    issue(2'd2, 1'b1);
    wait_done();
    repeat (40) @(negedge clk);
    chk(!stall_flag_o && !scl_low_o && !sda_low_o, "R12 R9 idle no trip",
        {stall_flag_o, scl_low_o, sda_low_o}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule